// File: doc/BRIEF.md
# SPI Burst Register Accessor

This block is an SPI target (clock polarity 0, phase 0) that turns one chip-select frame into a burst of byte accesses on a synchronous register bus. Each frame opens with a four-byte header. The header gives a 16-bit start address, a direction flag and a 15-bit byte count. The payload follows in the same frame. Each payload byte becomes one register-bus access, and the address moves up by one after each access.

Because the count sits in the header, the count alone decides where the burst ends. Bytes clocked past the count do nothing. A frame that ends before the count is used up raises a one-cycle length-error pulse. For reads, the block fetches each byte from the bus before its first bit is due on the serial output, so the bytes of a burst follow one another with no gap. The serial pins are oversampled by the system clock, so SCLK must stay high and low for at least four clock cycles each.

Top module: `spi_burst_access`

## Requirements
- R1: Header bytes arrive MSB first in this order: address bits 15:8, address bits 7:0, a control byte, then count bits 7:0. Control bit 7 is the direction (1 = write, 0 = read). Control bits 6:0 are count bits 14:8, which gives a 15-bit count.
- R2: In a write burst, the k-th payload byte (k from 0) produces one cycle of bus_wr with bus_addr = start + k (mod 2^16) and bus_wdata = that byte.
- R3: In a read burst, the k-th byte shifted out on spi_miso equals the bus_rdata returned for bus_addr = start + k (mod 2^16). bus_rdata is taken in the clock cycle after bus_rd. spi_miso changes after falling SCLK edges and is sampled by the host on rising edges, MSB first.
- R4: A count of 1 makes exactly one access. A count of 2 moves a 16-bit value big-endian: the high byte goes to the start address and the low byte to start + 1.
- R5: A count of 0 ends the frame with no bus access and no length error.
- R6: Once the count is used up, further payload bytes cause no write, and a read shifts them out as 0x00. spi_miso is 0 during the header and during write bursts.
- R7: If chip select rises with a header partly received, or with fewer payload bytes completed than the count, len_err is high for exactly one cycle. Writes already made stay in place. A complete frame gives no pulse.
- R8: bus_wr and bus_rd are never high together, and no access starts while chip select is deasserted.
- R9: While rst is high, and right after it, bus_wr, bus_rd, len_err and spi_miso are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| bus_addr | output | 16 | Register-bus byte address |
| bus_wr | output | 1 | One-cycle write strobe |
| bus_rd | output | 1 | One-cycle read strobe |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid the cycle after bus_rd |
| len_err | output | 1 | One-cycle pulse on a short frame |

## Verification
The assertions check on every cycle that the two strobes are exclusive, that the bus and spi_miso stay quiet while chip select is deasserted, that len_err is a single-cycle pulse, and that successive accesses within a frame step the address by one with 16-bit wrap. Only the bench scenarios can show that the header fields decode into the right count and direction, that read data arrives without a gap and in the right order, that a 16-bit value is big-endian, that bytes past the count are dropped or read as zero, and that short frames raise the error while keeping earlier writes.

// File: rtl/sbx_pkg.sv
package sbx_pkg;
    localparam int ADDR_W = 16;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 15;
    localparam int BIT_W  = $clog2(BYTE_W);
    localparam int HDR_BYTES = 4;
    localparam int HIDX_W = $clog2(HDR_BYTES);

    typedef enum logic {PH_HDR, PH_DATA} phase_t;

    typedef struct packed {
        logic             wr;
        logic [CNT_W-1:0] cnt;
    } ctl_t;

    // direction flag sits above the seven high count bits
    function automatic ctl_t decode_ctl(input logic [BYTE_W-1:0] hi,
                                        input logic [BYTE_W-1:0] lo);
        ctl_t c;
        c.wr  = hi[BYTE_W-1];
        c.cnt = {hi[BYTE_W-2:0], lo};
        return c;
    endfunction
endpackage

// File: rtl/sbx_front.sv
module sbx_front (
    input  logic clk,
    input  logic rst,
    input  logic spi_sclk,
    input  logic spi_cs_n,
    input  logic spi_mosi,
    output logic active,
    output logic rise,
    output logic fall,
    output logic cs_end,
    output logic mosi_s
);
    logic sclk_q, sclk_d, cs_q, cs_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= 1'b0;
            sclk_d <= 1'b0;
            cs_q   <= 1'b1;
            cs_d   <= 1'b1;
            mosi_s <= 1'b0;
        end else begin
            sclk_q <= spi_sclk;
            sclk_d <= sclk_q;
            cs_q   <= spi_cs_n;
            cs_d   <= cs_q;
            mosi_s <= spi_mosi;
        end
    end

    assign active = ~cs_q;
    assign rise   = active & sclk_q & ~sclk_d;
    assign fall   = active & ~sclk_q & sclk_d;
    assign cs_end = cs_q & ~cs_d;
endmodule

// File: rtl/sbx_rx.sv
module sbx_rx
    import sbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic              rise,
    input  logic              mosi_s,
    output logic [BIT_W-1:0]  bit_cnt,
    output logic              byte_done,
    output logic [BYTE_W-1:0] rx_byte
);
    logic [BYTE_W-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            sh      <= '0;
            bit_cnt <= '0;
        end else if (rise) begin
            sh      <= {sh[BYTE_W-2:0], mosi_s};
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

    assign byte_done = rise && (bit_cnt == BIT_W'(BYTE_W - 1));
    assign rx_byte   = {sh[BYTE_W-2:0], mosi_s};
endmodule

// File: rtl/sbx_tx.sv
module sbx_tx
    import sbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic              fall,
    input  logic [BIT_W-1:0]  bit_cnt,
    input  logic [BYTE_W-1:0] tx_next,
    output logic              spi_miso
);
    logic [BYTE_W-1:0] sh;

    // a fall with a zero bit count starts a byte: load the prefetched value
    always_ff @(posedge clk) begin
        if (rst || !active)
            sh <= '0;
        else if (fall)
            sh <= (bit_cnt == '0) ? tx_next : {sh[BYTE_W-2:0], 1'b0};
    end

    assign spi_miso = sh[BYTE_W-1];
endmodule

// File: rtl/sbx_seq.sv
module sbx_seq
    import sbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic              cs_end,
    input  logic              byte_done,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic [BIT_W-1:0]  bit_cnt,
    input  logic [BYTE_W-1:0] bus_rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_wr,
    output logic              bus_rd,
    output logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] tx_next,
    output logic              len_err
);
    phase_t            phase;
    logic [HIDX_W-1:0] hidx;
    logic [ADDR_W-1:0] addr;
    logic [BYTE_W-1:0] ctl_hi;
    logic              is_wr;
    logic [CNT_W-1:0]  left;
    logic [CNT_W-1:0]  fetch_left;
    logic              rd_pend;
    ctl_t              ctl;

    assign ctl = decode_ctl(ctl_hi, rx_byte);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= PH_HDR;
            hidx       <= '0;
            addr       <= '0;
            ctl_hi     <= '0;
            is_wr      <= 1'b0;
            left       <= '0;
            fetch_left <= '0;
            rd_pend    <= 1'b0;
            tx_next    <= '0;
            bus_addr   <= '0;
            bus_wr     <= 1'b0;
            bus_rd     <= 1'b0;
            bus_wdata  <= '0;
            len_err    <= 1'b0;
        end else begin
            bus_wr  <= 1'b0;
            bus_rd  <= 1'b0;
            len_err <= 1'b0;
            rd_pend <= bus_rd;
            if (rd_pend)
                tx_next <= bus_rdata;
            if (!active) begin
                if (cs_end)
                    len_err <= (phase == PH_HDR) ? (hidx != '0 || bit_cnt != '0)
                                                 : (left != '0);
                phase      <= PH_HDR;
                hidx       <= '0;
                left       <= '0;
                fetch_left <= '0;
                tx_next    <= '0;
            end else if (byte_done) begin
                if (phase == PH_HDR) begin
                    hidx <= hidx + 1'b1;
                    case (hidx)
                        2'd0: addr[ADDR_W-1:BYTE_W] <= rx_byte;
                        2'd1: addr[BYTE_W-1:0]      <= rx_byte;
                        2'd2: ctl_hi                <= rx_byte;
                        default: begin
                            phase <= PH_DATA;
                            is_wr <= ctl.wr;
                            left  <= ctl.cnt;
                            if (!ctl.wr && ctl.cnt != '0) begin
                                bus_rd     <= 1'b1;
                                bus_addr   <= addr;
                                addr       <= addr + 1'b1;
                                fetch_left <= ctl.cnt - 1'b1;
                            end else begin
                                fetch_left <= '0;
                            end
                        end
                    endcase
                end else begin
                    if (left != '0)
                        left <= left - 1'b1;
                    if (is_wr) begin
                        tx_next <= '0;
                        if (left != '0) begin
                            bus_wr    <= 1'b1;
                            bus_addr  <= addr;
                            bus_wdata <= rx_byte;
                            addr      <= addr + 1'b1;
                        end
                    end else if (fetch_left != '0) begin
                        bus_rd     <= 1'b1;
                        bus_addr   <= addr;
                        addr       <= addr + 1'b1;
                        fetch_left <= fetch_left - 1'b1;
                    end else begin
                        tx_next <= '0;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/spi_burst_access.sv
module spi_burst_access
    import sbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_sclk,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_wr,
    output logic              bus_rd,
    output logic [BYTE_W-1:0] bus_wdata,
    input  logic [BYTE_W-1:0] bus_rdata,
    output logic              len_err
);
    logic              active, rise, fall, cs_end, mosi_s, byte_done;
    logic [BIT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] rx_byte, tx_next;

    sbx_front u_front (
        .clk(clk), .rst(rst), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .active(active), .rise(rise), .fall(fall),
        .cs_end(cs_end), .mosi_s(mosi_s)
    );

    sbx_rx u_rx (
        .clk(clk), .rst(rst), .active(active), .rise(rise), .mosi_s(mosi_s),
        .bit_cnt(bit_cnt), .byte_done(byte_done), .rx_byte(rx_byte)
    );

    sbx_seq u_seq (
        .clk(clk), .rst(rst), .active(active), .cs_end(cs_end),
        .byte_done(byte_done), .rx_byte(rx_byte), .bit_cnt(bit_cnt),
        .bus_rdata(bus_rdata), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .tx_next(tx_next),
        .len_err(len_err)
    );

    sbx_tx u_tx (
        .clk(clk), .rst(rst), .active(active), .fall(fall),
        .bit_cnt(bit_cnt), .tx_next(tx_next), .spi_miso(spi_miso)
    );
endmodule

// File: rtl/sbx_checker.sv
module sbx_checker
    import sbx_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              spi_cs_n,
    input logic              spi_miso,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic              len_err
);
    logic              have_prev;
    logic [ADDR_W-1:0] prev_addr;

    always_ff @(posedge clk) begin
        if (rst || spi_cs_n) begin
            have_prev <= 1'b0;
            prev_addr <= '0;
        end else if (bus_wr || bus_rd) begin
            have_prev <= 1'b1;
            prev_addr <= bus_addr;
        end
    end

    a_r8_strobe_excl: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && bus_rd));

    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2)) |-> (!bus_wr && !bus_rd));

    a_r6_miso_idle: assert property (@(posedge clk) disable iff (rst)
        (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2)) |-> !spi_miso);

    a_r7_err_single: assert property (@(posedge clk) disable iff (rst)
        len_err |=> !len_err);

    a_r2_addr_step: assert property (@(posedge clk) disable iff (rst)
        ((bus_wr || bus_rd) && have_prev) |-> (bus_addr == prev_addr + 1'b1));
endmodule

bind spi_burst_access sbx_checker u_chk (
    .clk(clk), .rst(rst), .spi_cs_n(spi_cs_n), .spi_miso(spi_miso),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd), .len_err(len_err)
);

// File: tb/spi_burst_access_bench.sv
module spi_burst_access_bench;
    localparam int HALF = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        spi_sclk = 1'b0;
    logic        spi_cs_n = 1'b1;
    logic        spi_mosi = 1'b0;
    logic        spi_miso;
    logic [15:0] bus_addr;
    logic        bus_wr, bus_rd, len_err;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata = 8'h00;

    int checks = 0;
    int errors = 0;
    int wcnt = 0;
    int rcnt = 0;
    int err_pulses = 0;
    int idle_acc = 0;
    logic [15:0] wlog_a [16];
    logic [7:0]  wlog_d [16];
    logic [7:0]  wbuf [16];
    logic [7:0]  rbuf [16];
    logic [7:0]  hdr_or;

    always #5 clk = ~clk;

    spi_burst_access u_spi_burst_access (
        .clk(clk), .rst(rst), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .len_err(len_err)
    );

    function automatic logic [7:0] fexp(input logic [15:0] a);
        return (a[7:0] + 8'h3C) ^ a[15:8];
    endfunction

    // register-bus model: data valid in the cycle after bus_rd
    always @(posedge clk) begin
        if (bus_rd) begin
            bus_rdata <= fexp(bus_addr);
            rcnt <= rcnt + 1;
        end
        if (bus_wr) begin
            if (wcnt < 16) begin
                wlog_a[wcnt] <= bus_addr;
                wlog_d[wcnt] <= bus_wdata;
            end
            wcnt <= wcnt + 1;
        end
        if (len_err) err_pulses <= err_pulses + 1;
        if ((bus_wr || bus_rd) && spi_cs_n) idle_acc <= idle_acc + 1;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            spi_mosi = tx[i];
            repeat (HALF) @(negedge clk);
            rx[i] = spi_miso;
            spi_sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            spi_sclk = 1'b0;
        end
    endtask

    task automatic fbegin();
        spi_cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic fend();
        repeat (HALF) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    task automatic hdr(input logic [15:0] a, input logic wr, input logic [14:0] cnt);
        logic [7:0] r;
        hdr_or = 8'h00;
        xbyte(a[15:8], r);               hdr_or |= r;
        xbyte(a[7:0], r);                hdr_or |= r;
        xbyte({wr, cnt[14:8]}, r);       hdr_or |= r;
        xbyte(cnt[7:0], r);              hdr_or |= r;
    endtask

    task automatic wr_frame(input logic [15:0] a, input logic [14:0] cnt, input int nb);
        logic [7:0] r;
        wcnt = 0;
        fbegin();
        hdr(a, 1'b1, cnt);
        for (int k = 0; k < nb; k++) xbyte(wbuf[k], r);
        fend();
    endtask

    task automatic rd_frame(input logic [15:0] a, input logic [14:0] cnt, input int nb);
        logic [7:0] r;
        rcnt = 0;
        fbegin();
        hdr(a, 1'b0, cnt);
        for (int k = 0; k < nb; k++) begin
            xbyte(8'hFF, r);
            rbuf[k] = r;
        end
        fend();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] bases [2];
        int e0;
        repeat (4) @(negedge clk);
        // R9: outputs quiet in reset
        chk("R9 miso", spi_miso, 0);
        chk("R9 strobes", {bus_wr, bus_rd, len_err}, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9 after reset", {spi_miso, bus_wr, bus_rd, len_err}, 0);

        // R2 / R4: write sweep with 16-bit wrap
        bases[0] = 16'h1234; bases[1] = 16'hFFFC;
        for (int b = 0; b < 2; b++) begin
            for (int n = 1; n <= 6; n++) begin
                e0 = err_pulses;
                for (int k = 0; k < n; k++) wbuf[k] = 8'(bases[b][7:0] + k * 7 + n);
                wr_frame(bases[b], 15'(n), n);
                chk("R2 write count", wcnt, n);
                for (int k = 0; k < n; k++) begin
                    chk("R2 write addr", wlog_a[k], 16'(bases[b] + k));
                    chk("R2 write data", wlog_d[k], wbuf[k]);
                end
                chk("R7 no error on full write", err_pulses, e0);
                chk("R6 miso zero in header", hdr_or, 0);
            end
        end

        // R3: read sweep with 16-bit wrap and gapless bytes
        bases[0] = 16'h0100; bases[1] = 16'hFFFD;
        for (int b = 0; b < 2; b++) begin
            for (int n = 1; n <= 6; n++) begin
                e0 = err_pulses;
                rd_frame(bases[b], 15'(n), n);
                chk("R3 read strobes", rcnt, n);
                for (int k = 0; k < n; k++)
                    chk("R3 read byte", rbuf[k], fexp(16'(bases[b] + k)));
                chk("R7 no error on full read", err_pulses, e0);
            end
        end

        // R4: 16-bit big-endian write and read
        wbuf[0] = 8'hBE; wbuf[1] = 8'hEF;
        wr_frame(16'h0040, 15'd2, 2);
        chk("R4 write16 high byte", {wlog_a[0], wlog_d[0]}, {16'h0040, 8'hBE});
        chk("R4 write16 low byte",  {wlog_a[1], wlog_d[1]}, {16'h0041, 8'hEF});
        rd_frame(16'h2000, 15'd2, 2);
        chk("R4 read16 value", {rbuf[0], rbuf[1]}, {fexp(16'h2000), fexp(16'h2001)});

        // R5: zero count
        e0 = err_pulses;
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
        rcnt = 0;
        wr_frame(16'h0500, 15'd0, 3);
        chk("R5 zero write no access", wcnt + rcnt, 0);
        rd_frame(16'h0500, 15'd0, 3);
        chk("R5 zero read no access", rcnt, 0);
        chk("R5 zero read bytes", {rbuf[0], rbuf[1], rbuf[2]}, 0);
        chk("R5 zero no error", err_pulses, e0);

        // R6: bytes past the count
        for (int k = 0; k < 5; k++) wbuf[k] = 8'(8'hA0 + k);
        wr_frame(16'h0600, 15'd2, 5);
        chk("R6 excess write ignored", wcnt, 2);
        chk("R6 last kept write", {wlog_a[1], wlog_d[1]}, {16'h0601, 8'hA1});
        rd_frame(16'h0700, 15'd2, 4);
        chk("R6 excess read strobes", rcnt, 2);
        chk("R6 excess read zeros", {rbuf[2], rbuf[3]}, 0);
        chk("R6 counted read bytes", {rbuf[0], rbuf[1]}, {fexp(16'h0700), fexp(16'h0701)});

        // R7: short write frame keeps its writes
        e0 = err_pulses;
        wbuf[0] = 8'h5A; wbuf[1] = 8'hC3;
        wr_frame(16'h0800, 15'd4, 2);
        chk("R7 short write kept", wcnt, 2);
        chk("R7 short write data", {wlog_d[0], wlog_d[1]}, {8'h5A, 8'hC3});
        chk("R7 short write pulse", err_pulses, e0 + 1);
        // R7: short read frame
        e0 = err_pulses;
        rd_frame(16'h0900, 15'd3, 1);
        chk("R7 short read pulse", err_pulses, e0 + 1);
        // R7: partial header
        e0 = err_pulses;
        wcnt = 0; rcnt = 0;
        begin
            logic [7:0] r;
            fbegin();
            xbyte(8'h12, r);
            xbyte(8'h34, r);
            fend();
        end
        chk("R7 partial header pulse", err_pulses, e0 + 1);
        chk("R7 partial header no access", wcnt + rcnt, 0);

        // R1: count high bits from control bits 6:0 (count 0x0102)
        e0 = err_pulses;
        for (int k = 0; k < 3; k++) wbuf[k] = 8'(8'h70 + k);
        wr_frame(16'h3000, 15'h0102, 3);
        chk("R1 direction flag selects write", wcnt, 3);
        chk("R1 count above 255 leaves frame short", err_pulses, e0 + 1);
        chk("R1 address from first two bytes", wlog_a[0], 16'h3000);

        // R8: no access while deselected
        chk("R8 idle accesses", idle_acc, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule